// File: doc/BRIEF.md
# Two-Level Translation Tag Lookup

This block looks up a virtual address in a two-part translation tag store and returns, one cycle later, whether an entry matched and which one. The first part is set-associative (8 ways by 256 sets by default). It uses one page size for the whole part, and that size is supplied with the request. The second part is a small fully associative array (64 entries by default) in which every entry carries its own page size. Each entry describes an even/odd pair of pages. Its stored page-pair tag therefore holds virtual address bits from bit 13 upward. The compare ignores all bits below the page-size-plus-one boundary.

Software or a refill engine fills and clears entries through a single write port that is addressed by the same flat index the lookup reports. Each entry stores an enable bit, the page-pair tag, an address space identifier, a page size (used only in the fully associative part) and a global bit taken from the even half of the entry. Permission checks and the physical halves of the entries are handled elsewhere.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is disabled, `res_valid` and `res_hit` are 0, and any lookup misses.
- R2: A lookup presented with `lk_en` high at a clock edge produces `res_valid`=1 and its result after that edge. In a cycle after `lk_en` was low, `res_valid` and `res_hit` are 0.
- R3: An entry matches only if its enable bit is set and either its global bit is set or its stored ASID equals `lk_asid`.
- R4: In the set-associative part, with page size P = `lk_ps` (P ≥ 12), the set is bits [7:0] of VA >> (P+1). The tag compare checks VA bits [47:P+1] against the stored tag bits [34:P−12], where the stored tag holds VA[47:13]. VA bits below P+1 are ignored.
- R5: A set-associative hit in way w, set s reports `res_idx` = w×256 + s.
- R6: When several set-associative ways match, the lowest-numbered way is reported.
- R7: The fully associative part is reported only when no set-associative way matches.
- R8: Fully associative entry n uses its own stored page size in place of P. Its hit reports `res_idx` = 2048 + n, and the lowest matching n wins.
- R9: A write with `wr_idx` below 2048 targets way `wr_idx`[10:8], set `wr_idx`[7:0]. A write with `wr_idx` from 2048 to 2111 targets fully associative entry `wr_idx`−2048. Writing `wr_e`=0 makes that entry miss.
- R10: A write in the same cycle as a lookup does not change that lookup's result; it affects only later lookups.
- R11: On a miss, `res_hit` is 0 and `res_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 48 | Virtual address to look up |
| lk_asid | input | 10 | Current address space identifier |
| lk_ps | input | 6 | Page size (log2 bytes) for the set-associative part |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 12 | Flat index of the entry written |
| wr_e | input | 1 | Enable bit written |
| wr_vppn | input | 35 | Page-pair tag written (VA[47:13]) |
| wr_asid | input | 10 | ASID written |
| wr_ps | input | 6 | Page size written (fully associative entries) |
| wr_g | input | 1 | Global bit written (from the even half) |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | An entry matched |
| res_idx | output | 12 | Flat index of the matching entry |

## Verification
On every cycle the assertions check the result timing and the output shape. A hit must follow a request. An idle cycle must produce no valid result. A reported index must stay inside the store, and a miss must report index zero. A request that hits a set-associative way must report an index from that part. Which entry is chosen for a given address, ASID and page size can only be shown by the bench's scenarios. These cover ignored low address bits, way ordering, the per-entry page size in the fully associative part, clearing through the write map, and a write racing a lookup.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
   // The stored page-pair tag starts at this virtual address bit.
   localparam int TAG_LSB = 13;

   // Number of tag bits below the page-pair boundary for page size ps.
   function automatic int pair_shift(input int ps);
      return (ps > TAG_LSB - 1) ? ps - (TAG_LSB - 1) : 0;
   endfunction
endpackage

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
   parameter int N   = 8,
   localparam int W  = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/tlb_sa_way.sv
module tlb_sa_way #(
   parameter int SETS   = 256,
   parameter int ASID_W = 10,
   parameter int TAG_W  = 35,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SET_W-1:0]  wr_set,
   input  logic              wr_e,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_g,
   input  logic [SET_W-1:0]  rd_set,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic [TAG_W-1:0]  rd_mask,
   input  logic [ASID_W-1:0] rd_asid,
   output logic              hit
);
   logic [SETS-1:0]   en_q;
   logic [SETS-1:0]   g_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [ASID_W-1:0] asid_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q[wr_set] <= wr_e;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         g_q[wr_set]    <= wr_g;
         tag_q[wr_set]  <= wr_tag;
         asid_q[wr_set] <= wr_asid;
      end
   end

   always_comb begin
      hit = en_q[rd_set]
         && (g_q[rd_set] || (asid_q[rd_set] == rd_asid))
         && (((tag_q[rd_set] ^ rd_tag) & rd_mask) == '0);
   end
endmodule

// File: rtl/tlb_fa_array.sv
module tlb_fa_array
   import tlb_lookup_pkg::*;
#(
   parameter int N      = 64,
   parameter int ASID_W = 10,
   parameter int TAG_W  = 35,
   parameter int PS_W   = 6,
   localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_e,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PS_W-1:0]   wr_ps,
   input  logic              wr_g,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic [ASID_W-1:0] rd_asid,
   output logic [N-1:0]      hit_vec
);
   for (genvar n = 0; n < N; n++) begin : g_ent
      logic              en_q, g_q;
      logic [TAG_W-1:0]  tag_q;
      logic [ASID_W-1:0] asid_q;
      logic [PS_W-1:0]   ps_q;
      logic [TAG_W-1:0]  mask;
      logic              sel;

      assign sel = wr_en && (wr_sel == SEL_W'(n));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   en_q <= 1'b0;
         else if (sel) en_q <= wr_e;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            g_q    <= wr_g;
            tag_q  <= wr_tag;
            asid_q <= wr_asid;
            ps_q   <= wr_ps;
         end
      end

      always_comb begin
         mask       = {TAG_W{1'b1}} << pair_shift(int'(ps_q));
         hit_vec[n] = en_q && (g_q || (asid_q == rd_asid))
                   && (((tag_q ^ rd_tag) & mask) == '0);
      end
   end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
   import tlb_lookup_pkg::*;
#(
   parameter int VA_W   = 48,
   parameter int ASID_W = 10,
   parameter int PS_W   = 6,
   parameter int WAYS   = 8,
   parameter int SETS   = 256,
   parameter int FA_N   = 64,
   localparam int TAG_W    = VA_W - TAG_LSB,
   localparam int SET_W    = $clog2(SETS),
   localparam int WAY_W    = $clog2(WAYS),
   localparam int FA_W     = (FA_N > 1) ? $clog2(FA_N) : 1,
   localparam int SA_TOTAL = WAYS * SETS,
   localparam int TOTAL    = SA_TOTAL + FA_N,
   localparam int IDX_W    = $clog2(TOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_en,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [PS_W-1:0]   lk_ps,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_e,
   input  logic [TAG_W-1:0]  wr_vppn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PS_W-1:0]   wr_ps,
   input  logic              wr_g,
   output logic              res_valid,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_idx
);
   if ((SETS & (SETS - 1)) != 0 || SETS < 2) begin : g_bad_sets
      $error("tlb_lookup: SETS must be a power of two");
   end
   if ((WAYS & (WAYS - 1)) != 0 || WAYS < 2) begin : g_bad_ways
      $error("tlb_lookup: WAYS must be a power of two, at least 2");
   end
   if (TAG_W <= SET_W) begin : g_bad_va
      $error("tlb_lookup: VA_W too small for the set index");
   end

   // Lookup address preparation (global page size)
   logic [TAG_W-1:0] va_tag, va_shifted, sa_mask;
   logic [SET_W-1:0] rd_set;
   always_comb begin
      va_tag     = lk_va[VA_W-1:TAG_LSB];
      va_shifted = va_tag >> pair_shift(int'(lk_ps));
      sa_mask    = {TAG_W{1'b1}} << pair_shift(int'(lk_ps));
      rd_set     = va_shifted[SET_W-1:0];
   end

   // Write address decode
   logic             wr_sa, wr_fa;
   logic [IDX_W-1:0] fa_off;
   assign wr_sa  = wr_en && (wr_idx < IDX_W'(SA_TOTAL));
   assign wr_fa  = wr_en && !wr_sa && (wr_idx < IDX_W'(TOTAL));
   assign fa_off = wr_idx - IDX_W'(SA_TOTAL);

   // Set-associative ways
   logic [WAYS-1:0] sa_hit;
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      tlb_sa_way #(.SETS(SETS), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_way (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_sa && (wr_idx[SET_W +: WAY_W] == WAY_W'(w))),
         .wr_set (wr_idx[SET_W-1:0]),
         .wr_e   (wr_e),
         .wr_tag (wr_vppn),
         .wr_asid(wr_asid),
         .wr_g   (wr_g),
         .rd_set (rd_set),
         .rd_tag (va_tag),
         .rd_mask(sa_mask),
         .rd_asid(lk_asid),
         .hit    (sa_hit[w])
      );
   end

   logic             sa_any;
   logic [WAY_W-1:0] sa_way;
   tlb_prio_enc #(.N(WAYS)) u_way_pick (.req(sa_hit), .any(sa_any), .idx(sa_way));

   // Fully associative array
   logic [FA_N-1:0] fa_hit;
   tlb_fa_array #(.N(FA_N), .ASID_W(ASID_W), .TAG_W(TAG_W), .PS_W(PS_W)) u_fa (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_fa),
      .wr_sel (fa_off[FA_W-1:0]),
      .wr_e   (wr_e),
      .wr_tag (wr_vppn),
      .wr_asid(wr_asid),
      .wr_ps  (wr_ps),
      .wr_g   (wr_g),
      .rd_tag (va_tag),
      .rd_asid(lk_asid),
      .hit_vec(fa_hit)
   );

   logic            fa_any;
   logic [FA_W-1:0] fa_sel;
   tlb_prio_enc #(.N(FA_N)) u_fa_pick (.req(fa_hit), .any(fa_any), .idx(fa_sel));

   // Result selection and registration
   logic             nxt_hit;
   logic [IDX_W-1:0] nxt_idx;
   always_comb begin
      nxt_hit = lk_en && (sa_any || fa_any);
      nxt_idx = '0;
      if (lk_en && sa_any)      nxt_idx = IDX_W'({sa_way, rd_set});
      else if (lk_en && fa_any) nxt_idx = IDX_W'(SA_TOTAL) + IDX_W'(fa_sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_idx   <= '0;
      end else begin
         res_valid <= lk_en;
         res_hit   <= nxt_hit;
         res_idx   <= nxt_idx;
      end
   end

   AST_HIT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> $past(lk_en));                                          // R2
   AST_IDLE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_en |=> (!res_valid && !res_hit));                               // R2
   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> (res_idx < IDX_W'(TOTAL)));                             // R8
   AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_idx == '0));                                      // R11
   AST_SA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en && sa_any) |=> (res_hit && res_idx < IDX_W'(SA_TOTAL)));      // R7
endmodule

// File: tb/tlb_lookup_test.sv
`timescale 1ns/1ps
module tlb_lookup_test;
   localparam int SA_TOTAL = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_en = 1'b0;
   logic [47:0] lk_va = '0;
   logic [9:0]  lk_asid = '0;
   logic [5:0]  lk_ps = 6'd14;
   logic        wr_en = 1'b0;
   logic [11:0] wr_idx = '0;
   logic        wr_e = 1'b0;
   logic [34:0] wr_vppn = '0;
   logic [9:0]  wr_asid = '0;
   logic [5:0]  wr_ps = '0;
   logic        wr_g = 1'b0;
   logic        res_valid, res_hit;
   logic [11:0] res_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tlb_lookup uut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input bit e, input logic [47:0] va,
                     input int asid, input int ps, input bit g);
      @(negedge clk);
      wr_en = 1; wr_idx = 12'(idx); wr_e = e; wr_vppn = va[47:13];
      wr_asid = 10'(asid); wr_ps = 6'(ps); wr_g = g;
      @(negedge clk);
      wr_en = 0;
   endtask

   // Returns hit ? idx : -1
   task automatic look(input logic [47:0] va, input int asid, input int ps,
                       output int res);
      @(negedge clk);
      lk_en = 1; lk_va = va; lk_asid = 10'(asid); lk_ps = 6'(ps);
      @(negedge clk);
      lk_en = 0;
      check("R2 valid", int'(res_valid), 1);
      res = res_hit ? int'(res_idx) : -1;
      if (!res_hit) check("R11 miss idx", int'(res_idx), 0);
   endtask

   function automatic int set_of(input logic [47:0] va, input int ps);
      return int'((va >> (ps + 1)) & 48'hFF);
   endfunction

   localparam logic [47:0] VA1 = 48'h3A5C_6F12_C000;
   localparam logic [47:0] VA2 = 48'h7700_1234_5678;

   task automatic t_reset();
      int r;
      check("R1 valid at reset", int'(res_valid), 0);
      check("R1 hit at reset", int'(res_hit), 0);
      look(VA1, 5, 14, r);
      check("R1 empty lookup", r, -1);
      @(negedge clk);
      check("R2 idle not valid", int'(res_valid), 0);
   endtask

   task automatic t_sa_match();
      int r, s;
      s = set_of(VA1, 14);
      wr(3 * 256 + s, 1, VA1, 5, 0, 0);
      look(VA1, 5, 14, r);
      check("R5 way3 index", r, 3 * 256 + s);
      look(VA1, 6, 14, r);
      check("R3 asid mismatch", r, -1);
      wr(3 * 256 + s, 1, VA1, 5, 0, 1);
      look(VA1, 6, 14, r);
      check("R3 global hit", r, 3 * 256 + s);
      look(VA1 ^ 48'h6FFF, 6, 14, r);
      check("R4 low bits ignored", r, 3 * 256 + s);
      look(VA1 ^ (48'h1 << 30), 6, 14, r);
      check("R4 high bit differs", r, -1);
   endtask

   task automatic t_way_order();
      int r, s;
      s = set_of(VA1, 14);
      wr(6 * 256 + s, 1, VA1, 5, 0, 1);
      wr(1 * 256 + s, 1, VA1, 5, 0, 0);
      look(VA1, 5, 14, r);
      check("R6 lowest way", r, 1 * 256 + s);
      look(VA1, 9, 14, r);
      check("R6 way1 asid miss, way3 global", r, 3 * 256 + s);
   endtask

   task automatic t_sa_then_fa();
      int r, s;
      s = set_of(VA1, 14);
      wr(SA_TOTAL + 5, 1, VA1, 5, 14, 0);
      look(VA1, 5, 14, r);
      check("R7 sa before fa", r, 1 * 256 + s);
      wr(1 * 256 + s, 0, VA1, 5, 0, 0);
      wr(3 * 256 + s, 0, VA1, 5, 0, 0);
      wr(6 * 256 + s, 0, VA1, 5, 0, 0);
      look(VA1, 5, 14, r);
      check("R9 cleared ways, fa hit", r, SA_TOTAL + 5);
   endtask

   task automatic t_fa_pagesize();
      int r;
      logic [47:0] junk;
      junk = VA2 | 48'h15_6000;
      wr(SA_TOTAL + 9, 1, junk, 7, 21, 0);
      look(VA2 ^ 48'h3F_FFFF, 7, 14, r);
      check("R8 own page size", r, SA_TOTAL + 9);
      look(VA2 ^ 48'h40_0000, 7, 14, r);
      check("R8 bit above page pair", r, -1);
      wr(SA_TOTAL + 2, 1, VA2, 7, 21, 0);
      look(VA2, 7, 12, r);
      check("R8 lowest entry", r, SA_TOTAL + 2);
   endtask

   task automatic t_write_race();
      int r;
      @(negedge clk);
      lk_en = 1; lk_va = VA2; lk_asid = 10'd7; lk_ps = 6'd14;
      wr_en = 1; wr_idx = 12'(SA_TOTAL + 2); wr_e = 0;
      @(negedge clk);
      lk_en = 0; wr_en = 0;
      check("R10 in-flight hit", int'(res_hit), 1);
      check("R10 in-flight idx", int'(res_idx), SA_TOTAL + 2);
      look(VA2, 7, 14, r);
      check("R10 later lookup", r, SA_TOTAL + 9);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_sa_match();
      t_way_order();
      t_sa_then_fa();
      t_fa_pagesize();
      t_write_race();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule